// File: doc/BRIEF.md
# Pointer Metadata Untagging Unit

This unit turns a 64-bit virtual pointer that may carry software metadata in its upper bits into a plain address that the translation path can consume. Bit 63 of the pointer decides whether it belongs to the user half or the supervisor half of the address space. Two control words, which are copies of the processor's address-space control registers, choose whether metadata masking applies. A separate paging-depth bit then sets where the sign extension starts. The unit replaces every ignored bit with a copy of the highest address bit that is still valid. It also raises a flag when the resulting pointer is not canonical.

Results leave through a one-entry output register that uses a valid/ready handshake. An accepted input shows up at the output on the next clock edge. That result stays frozen while the consumer holds ready low. Page walks, TLB access, feature discovery and exception delivery are left to the surrounding pipeline. The fault flag is the only report the unit makes.

Top module: `ptr_untag_unit`

## Requirements
- R1: A pointer with bit 63 clear is a user pointer. When bit 62 of the user control word is set, result bits 62:57 become copies of address bit 56 and all other bits pass through.
- R2: For a user pointer with bit 62 of the user control word clear and bit 61 set, result bits 62:48 become copies of address bit 47 and all other bits pass through.
- R3: When bits 62 and 61 of the user control word are both set, a user pointer is masked as in R1, never as in R2.
- R4: A pointer with bit 63 set is a supervisor pointer. It is masked only when bit 28 of the supervisor control word is set. Masking copies bit 56 into bits 62:57 when the paging-depth input is 1 (five levels) and copies bit 47 into bits 62:48 when it is 0 (four levels).
- R5: When no mode applies to the pointer's class, the result equals the input address. User control bits have no effect on supervisor pointers, and the supervisor enable has no effect on user pointers.
- R6: Result bit 63 always equals input bit 63.
- R7: While masking is active, the fault flag is 1 exactly when address bit 63 differs from the sign-source bit (56 or 47).
- R8: While masking is inactive, the fault flag is 1 unless address bits 63:N all hold the same value. N is 56 when the paging-depth input is 1 and 47 when it is 0.
- R9: Only bits 62 and 61 of the user control word and bit 28 of the supervisor control word are examined. Every other control bit has no effect.
- R10: An input is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result is presented on the next edge. `in_ready` is high whenever the output register is empty or `out_ready` is high. The output holds steady while `out_valid` is high and `out_ready` is low.
- R11: Synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pointer is valid |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_addr | input | 64 | Tagged virtual pointer |
| user_ctl_word | input | 64 | User-space control word (bits 62, 61 used) |
| sup_ctl_word | input | 64 | Supervisor control word (bit 28 used) |
| five_level | input | 1 | 1 = five-level paging, 0 = four-level |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Untagged address |
| out_fault | output | 1 | Result is non-canonical |

## Verification
The bench tries each masking mode on pointers whose sign-source bit is 0 and then 1. Any error in which bit feeds the fill therefore shows up as a different value. It sets both user enables together to expose a wrong priority, and it crosses the pointer class with the enables of the other class to expose cross-talk between them. It sets every unused control bit to catch decode of the wrong position. Non-canonical pointers are checked under both paging depths, with and without masking, to tell the R7 rule from the R8 rule. A long stream of mixed pointers under irregular `out_ready` stalls tests ordering and the hold behaviour.

// File: rtl/untag_pkg.sv
package untag_pkg;

    localparam int ADDR_W     = 64;
    localparam int CTL_W      = 64;
    localparam int USR_HI_BIT = 62;
    localparam int USR_LO_BIT = 61;
    localparam int SUP_EN_BIT = 28;
    localparam int SIGN_HI    = 56;
    localparam int SIGN_LO    = 47;
    localparam int TOP_BIT    = ADDR_W - 1;

    typedef enum logic [1:0] {
        MASK_OFF = 2'd0,
        MASK_HI  = 2'd1,
        MASK_LO  = 2'd2
    } mask_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fault;
    } untag_result_t;

    // Copy bit 'src' into every bit between src+1 and TOP_BIT-1.
    function automatic logic [ADDR_W-1:0] fill_above(input logic [ADDR_W-1:0] a, input int src);
        logic [ADDR_W-1:0] r;
        r = a;
        for (int i = 0; i < TOP_BIT; i++) begin
            if (i > src) r[i] = a[src];
        end
        return r;
    endfunction

    // True when bits TOP_BIT down to lo all agree.
    function automatic logic span_uniform(input logic [ADDR_W-1:0] a, input int lo);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < TOP_BIT; i++) begin
            if (i >= lo && a[i] != a[TOP_BIT]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/untag_mode_decode.sv
module untag_mode_decode
    import untag_pkg::*;
#(
    parameter int CW  = CTL_W,
    parameter int UHI = USR_HI_BIT,
    parameter int ULO = USR_LO_BIT,
    parameter int SEN = SUP_EN_BIT
) (
    input  logic          is_sup,
    input  logic [CW-1:0] user_ctl,
    input  logic [CW-1:0] sup_ctl,
    input  logic          five_level,
    output mask_mode_e    mode
);
    always_comb begin
        mode = MASK_OFF;
        if (is_sup) begin
            if (sup_ctl[SEN]) mode = five_level ? MASK_HI : MASK_LO;
        end else if (user_ctl[UHI]) begin
            mode = MASK_HI;
        end else if (user_ctl[ULO]) begin
            mode = MASK_LO;
        end
    end
endmodule

// File: rtl/untag_mask_core.sv
module untag_mask_core
    import untag_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  mask_mode_e        mode,
    input  logic              five_level,
    output untag_result_t     res
);
    always_comb begin
        res.addr  = addr;
        res.fault = 1'b0;
        unique case (mode)
            MASK_HI: begin
                res.addr  = fill_above(addr, SIGN_HI);
                res.fault = addr[TOP_BIT] ^ addr[SIGN_HI];
            end
            MASK_LO: begin
                res.addr  = fill_above(addr, SIGN_LO);
                res.fault = addr[TOP_BIT] ^ addr[SIGN_LO];
            end
            default: begin
                res.addr  = addr;
                res.fault = !span_uniform(addr, five_level ? SIGN_HI : SIGN_LO);
            end
        endcase
    end
endmodule

// File: rtl/untag_out_stage.sv
module untag_out_stage
    import untag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  untag_result_t in_res,
    output logic          out_valid,
    input  logic          out_ready,
    output untag_result_t out_res
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) out_res <= in_res;
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_res)) // R10
        else $error("output changed during stall");

    AST_RESET_CLEARS_VALID: assert property (@(posedge clk)
        rst |=> !out_valid) // R11
        else $error("valid survived reset");

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready) // R10
        else $error("not ready while empty");
endmodule

// File: rtl/ptr_untag_unit.sv
module ptr_untag_unit
    import untag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CTL_W-1:0]  user_ctl_word,
    input  logic [CTL_W-1:0]  sup_ctl_word,
    input  logic              five_level,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault
);
    mask_mode_e    mode;
    untag_result_t comb_res;
    untag_result_t reg_res;

    untag_mode_decode u_decode (
        .is_sup     (in_addr[TOP_BIT]),
        .user_ctl   (user_ctl_word),
        .sup_ctl    (sup_ctl_word),
        .five_level (five_level),
        .mode       (mode)
    );

    untag_mask_core u_core (
        .addr       (in_addr),
        .mode       (mode),
        .five_level (five_level),
        .res        (comb_res)
    );

    untag_out_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_res    (comb_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (reg_res)
    );

    assign out_addr  = reg_res.addr;
    assign out_fault = reg_res.fault;

    AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_addr[TOP_BIT] == $past(in_addr[TOP_BIT])) // R6
        else $error("bit 63 altered");

    AST_SPLIT_TOP_FAULTS: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_addr[TOP_BIT] != out_addr[TOP_BIT-1]) |-> out_fault) // R8
        else $error("split top bits without fault");
endmodule

// File: tb/ptr_untag_unit_tb.sv
module ptr_untag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_addr = '0;
    logic [63:0] user_ctl_word = '0;
    logic [63:0] sup_ctl_word = '0;
    logic        five_level = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_addr;
    logic        out_fault;

    typedef struct {
        logic [63:0] addr;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   stall_on = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_untag_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .user_ctl_word(user_ctl_word), .sup_ctl_word(sup_ctl_word),
        .five_level(five_level), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_fault(out_fault)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(logic [63:0] a, logic [63:0] u, logic [63:0] s, logic fl, string tag);
        exp_t e;
        int   src;
        int   n;
        src = -1;
        if (!a[63]) begin
            if (u[62]) src = 56;           // R1, R3
            else if (u[61]) src = 47;      // R2
        end else if (s[28]) begin
            src = fl ? 56 : 47;            // R4
        end
        e.addr = a;
        e.fault = 1'b0;
        e.tag = tag;
        if (src >= 0) begin
            for (int i = src + 1; i < 63; i++) e.addr[i] = a[src];
            e.fault = a[63] != a[src];     // R7
        end else begin
            n = fl ? 56 : 47;
            for (int i = n; i < 63; i++) if (a[i] != a[63]) e.fault = 1'b1; // R8
        end
        return e;
    endfunction

    task automatic send(logic [63:0] a, logic [63:0] u, logic [63:0] s, logic fl, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr = a;
        user_ctl_word = u;
        sup_ctl_word = s;
        five_level = fl;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(a, u, s, fl, tag));
    endtask

    // Consumer ready pattern.
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= stall_on ? lfsr[0] : 1'b1;
    end

    // Monitor / scoreboard.
    logic [63:0] held_addr;
    logic        held_fault;
    bit          was_stalled = 0;
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (was_stalled) begin
                    checks++;
                    if (!out_valid || out_addr !== held_addr || out_fault !== held_fault) begin
                        errors++;
                        $display("FAIL R10 hold: got v=%0b %h/%0b expected v=1 %h/%0b",
                                 out_valid, out_addr, out_fault, held_addr, held_fault);
                    end
                end
                was_stalled = out_valid && !out_ready;
                held_addr = out_addr;
                held_fault = out_fault;
                if (out_valid && out_ready) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R10 unexpected output: got %h expected none", out_addr);
                    end else begin
                        e = exp_q.pop_front();
                        if (out_addr !== e.addr || out_fault !== e.fault) begin
                            errors++;
                            $display("FAIL %s: got %h fault=%0b expected %h fault=%0b",
                                     e.tag, out_addr, out_fault, e.addr, e.fault);
                        end
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [63:0] U57 = 64'h1 << 62;
    localparam logic [63:0] U48 = 64'h1 << 61;
    localparam logic [63:0] SEN = 64'h1 << 28;

    initial begin
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset: got v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
        end
        @(negedge clk);
        rst = 1'b0;

        send(64'h7E00_0012_3456_7890, U57, 0, 0, "R1 u57 sign0");
        send(64'h2100_ABCD_0000_0001, U57, 0, 1, "R1 u57 sign1");
        send(64'h7FFF_0000_1111_2222, U48, 0, 1, "R2 u48 sign0");
        send(64'h0AAA_8000_0000_0040, U48, 0, 0, "R2 u48 sign1");
        send(64'h5A5A_8000_0000_0000, U57 | U48, 0, 0, "R3 priority");
        send(64'h5B00_0000_0000_0000, U57 | U48, 0, 1, "R3 priority b56");
        send(64'hA500_1234_5678_9ABC, 0, SEN, 1, "R4 sup five-level");
        send(64'hC0DE_FFFF_8000_0000, 0, SEN, 0, "R4 sup four-level");
        send(64'h8123_4567_0000_0000, 0, SEN, 0, "R7 sup masked fault");
        send(64'h0000_7FFF_FFFF_F000, 0, 0, 0, "R5 user passthrough");
        send(64'hFF12_3400_0000_0000, U57 | U48, 0, 1, "R5 sup ignores user bits");
        send(64'h3C00_0000_0000_0010, 0, SEN, 1, "R5 user ignores sup bit");
        send(64'h0100_0000_0000_0000, 0, 0, 1, "R8 noncanon five");
        send(64'h0000_8000_0000_0000, 0, 0, 0, "R8 noncanon four");
        send(64'h0000_8000_0000_0000, 0, 0, 1, "R8 canon five");
        send(64'hFFFF_8000_0000_0000, 0, 0, 0, "R8 canon sup four");
        send(64'h7E00_0000_0000_0000, ~(U57 | U48), ~SEN, 1, "R9 other bits user");
        send(64'hAB00_0000_0000_0000, ~(U57 | U48), ~SEN, 0, "R9 other bits sup");
        send(64'h8000_0000_0000_0001, 0, 0, 1, "R6 top bit kept");

        stall_on = 1;
        for (int k = 0; k < 60; k++) begin
            logic [63:0] a;
            logic [63:0] u;
            logic [63:0] s;
            a = {$urandom, $urandom};
            u = {$urandom, $urandom};
            s = {$urandom, $urandom};
            send(a, u, s, k[0], "R10 stream");
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule